// File: doc/BRIEF.md
# Hybrid Echo Replica Canceller

This block removes the near-end echo that the two-wire/four-wire hybrid reflects from the receive path into the transmit path of a subscriber line. For every sample period, nominally at 16 kHz, the block builds an echo estimate from the receive stream. The estimate is the sum of an eight-tap FIR section and a second-order IIR section, and both sections read the same input history. The block subtracts the estimate from the transmit sample, saturates the difference and registers it.

Two lines share one set of multipliers. Each sample strobe carries a line index. The datapath takes that line's coefficient bank and its delay-line and feedback state, which are held in separate register storage for each line. Software loads the coefficients through a small write-only register port. A bypass control for each line disables cancellation, so the full transmit signal can be observed for loopback and return-loss measurement.

All coefficients reset to zero and bypass resets active. Cancellation is therefore inert until software has programmed every location and then cleared bypass.

Top module: `hyb_echo_cancel`

## Requirements
- R1: The FIR part of the estimate is floor((sum over k=0..7 of h_k * x[n-k]) / 2^15). The h_k are signed 16-bit Q1.15 and x[n] is the current receive sample.
- R2: The IIR part is a direct-form-I biquad with signed 16-bit Q2.14 coefficients. Its output is y[n] = sat16(floor((b0*x[n] + b1*x[n-1] + b2*x[n-2] - a1*y[n-1] - a2*y[n-2]) / 2^14)). The estimate is the FIR part plus y[n], and the feedback uses the saturated y values.
- R3: The input history and the IIR feedback history advance only on a cycle with `smp_valid` high, and only for the line given by `smp_line`.
- R4: Each line (`smp_line`/`cfg_line` 0 or 1) has its own coefficient bank and its own history. Samples or writes for one line do not change the results of the other line.
- R5: While a line's bypass is set, `tx_out` equals `tx_in` for that line's samples. The line's history still advances.
- R6: With bypass clear, `tx_out` = tx_in − estimate, saturated to the range −32768..32767.
- R7: `out_valid` is high in exactly the cycle after a cycle with `smp_valid` high. `tx_out` updates only then and holds otherwise.
- R8: After reset, all coefficients and histories are zero, bypass is set on both lines, `tx_out` is 0 and `out_valid` is 0.
- R9: The register map uses the 4-bit `cfg_addr`. Addresses 0..7 hold h_0..h_7. Addresses 8..12 hold b0, b1, b2, a1, a2. At address 13, a nonzero write sets bypass and a zero write clears it. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One sample for the selected line this cycle |
| smp_line | input | 1 | Line index of the sample |
| rx_in | input | 16 | Signed receive-path sample |
| tx_in | input | 16 | Signed transmit-path sample including echo |
| cfg_we | input | 1 | Register write strobe |
| cfg_line | input | 1 | Line whose bank is written |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Write data |
| out_valid | output | 1 | `tx_out` carries a new sample |
| tx_out | output | 16 | Signed echo-cancelled transmit sample |

## Verification
The bench builds the block with its default parameters: eight taps, two lines, 16-bit samples and coefficients, and a 40-bit accumulator. With these values the exact Q formats of R1 and R2 can be predicted by a longint model. Coefficients near ±1.0 and ±2.0 then push both the IIR feedback and the final difference into saturation. Because there are two lines, interleaved and idle-gapped strobes exercise the separation between lines and the hold behaviour.

// File: rtl/hyb_echo_cancel.sv
module hyb_echo_cancel #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int AW    = 40,
  parameter int NTAP  = 8,
  parameter int NLINE = 2,
  localparam int LW   = (NLINE > 1) ? $clog2(NLINE) : 1,
  localparam int NREG = NTAP + 6,
  localparam int ADW  = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [LW-1:0]        smp_line,
  input  logic signed [DW-1:0] rx_in,
  input  logic signed [DW-1:0] tx_in,
  input  logic                 cfg_we,
  input  logic [LW-1:0]        cfg_line,
  input  logic [ADW-1:0]       cfg_addr,
  input  logic [CW-1:0]        cfg_wdata,
  output logic                 out_valid,
  output logic signed [DW-1:0] tx_out
);
  localparam int FQ = CW - 1;
  localparam int IQ = CW - 2;
  localparam int NBQ = 5;
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - 1;

  logic signed [CW-1:0] fir_c [NLINE][NTAP];
  logic signed [CW-1:0] bq_c  [NLINE][NBQ];
  logic [NLINE-1:0]     byp_q;
  logic signed [DW-1:0] xh    [NLINE][NTAP-1];
  logic signed [DW-1:0] yh    [NLINE][2];

  function automatic logic signed [DW-1:0] sat(input logic signed [AW-1:0] v);
    if (v > MAXV)      return DW'(MAXV);
    else if (v < MINV) return DW'(MINV);
    else               return DW'(v);
  endfunction

  function automatic logic signed [AW-1:0] mul(input logic signed [DW-1:0] a,
                                               input logic signed [CW-1:0] b);
    logic signed [AW-1:0] ae, be;
    ae = AW'(a);
    be = AW'(b);
    return ae * be;
  endfunction

  logic signed [DW-1:0] xv    [NTAP];
  logic signed [AW-1:0] fprod [NTAP];

  assign xv[0] = rx_in;
  for (genvar k = 1; k < NTAP; k++) begin : g_tap
    assign xv[k] = xh[smp_line][k-1];
  end
  for (genvar k = 0; k < NTAP; k++) begin : g_prod
    assign fprod[k] = mul(xv[k], fir_c[smp_line][k]);
  end

  logic signed [AW-1:0] acc_fir, acc_bq, est, diff;
  logic signed [DW-1:0] bq_y, res;

  always_comb begin
    acc_fir = '0;
    for (int k = 0; k < NTAP; k++) acc_fir = acc_fir + fprod[k];
  end

  assign acc_bq = mul(xv[0], bq_c[smp_line][0])
                + mul(xv[1], bq_c[smp_line][1])
                + mul(xv[2], bq_c[smp_line][2])
                - mul(yh[smp_line][0], bq_c[smp_line][3])
                - mul(yh[smp_line][1], bq_c[smp_line][4]);
  assign bq_y = sat(acc_bq >>> IQ);
  assign est  = (acc_fir >>> FQ) + AW'(bq_y);
  assign diff = AW'(tx_in) - est;
  assign res  = byp_q[smp_line] ? tx_in : sat(diff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLINE; l++) begin
        for (int k = 0; k < NTAP; k++)   fir_c[l][k] <= '0;
        for (int k = 0; k < NBQ; k++)    bq_c[l][k]  <= '0;
        for (int k = 0; k < NTAP-1; k++) xh[l][k]    <= '0;
        yh[l][0] <= '0;
        yh[l][1] <= '0;
      end
      byp_q     <= '1;
      out_valid <= 1'b0;
      tx_out    <= '0;
    end else begin
      if (cfg_we && int'(cfg_line) < NLINE) begin
        if (int'(cfg_addr) < NTAP)
          fir_c[cfg_line][int'(cfg_addr)] <= cfg_wdata;
        else if (int'(cfg_addr) < NTAP + NBQ)
          bq_c[cfg_line][int'(cfg_addr) - NTAP] <= cfg_wdata;
        else if (int'(cfg_addr) == NTAP + NBQ)
          byp_q[cfg_line] <= |cfg_wdata;
      end
      out_valid <= smp_valid;
      if (smp_valid) begin
        xh[smp_line][0] <= rx_in;
        for (int k = 1; k < NTAP-1; k++) xh[smp_line][k] <= xh[smp_line][k-1];
        yh[smp_line][0] <= bq_y;
        yh[smp_line][1] <= yh[smp_line][0];
        tx_out <= res;
      end
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (!out_valid && $stable(tx_out))); // R7
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && byp_q[smp_line] && !cfg_we) |=> (tx_out == $past(tx_in))); // R5
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(xh[0][0]) && $stable(yh[0][0]))); // R3
  AST_LINE_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_line != LW'(NLINE-1)) |=> ($stable(xh[NLINE-1][0]) && $stable(yh[NLINE-1][0]))); // R4
endmodule

// File: tb/hyb_echo_cancel_test.sv
module hyb_echo_cancel_test;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, smp_line = 0, cfg_we = 0, cfg_line = 0;
  logic signed [15:0] rx_in = 0, tx_in = 0;
  logic [3:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic out_valid;
  logic signed [15:0] tx_out;

  hyb_echo_cancel uut (.clk, .rst_n, .smp_valid, .smp_line, .rx_in, .tx_in,
    .cfg_we, .cfg_line, .cfg_addr, .cfg_wdata, .out_valid, .tx_out);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  longint mf[2][8], mb[2][5], mx[2][8], my[2][2];
  bit mbyp[2];
  longint exp_out = 0;
  bit exp_v = 0;

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(string req);
    checks++;
    if (out_valid !== exp_v || longint'(tx_out) != exp_out) begin
      fails++;
      $display("FAIL %s: got valid=%0b out=%0d, expected valid=%0b out=%0d",
               req, out_valid, tx_out, exp_v, exp_out);
    end
  endtask

  task automatic put(bit v, int ln, int rx, int tx, string req);
    longint xs[8];
    longint af, ai, yi;
    smp_valid = v; smp_line = ln[0]; rx_in = 16'(rx); tx_in = 16'(tx); cfg_we = 0;
    exp_v = v;
    if (v) begin
      xs[0] = rx;
      for (int k = 1; k < 8; k++) xs[k] = mx[ln][k-1];
      af = 0;
      for (int k = 0; k < 8; k++) af += mf[ln][k] * xs[k];
      ai = mb[ln][0]*xs[0] + mb[ln][1]*xs[1] + mb[ln][2]*xs[2]
         - mb[ln][3]*my[ln][0] - mb[ln][4]*my[ln][1];
      yi = sat16(ai >>> 14);
      exp_out = mbyp[ln] ? longint'(tx) : sat16(longint'(tx) - ((af >>> 15) + yi));
      for (int k = 7; k > 0; k--) mx[ln][k] = mx[ln][k-1];
      mx[ln][0] = rx;
      my[ln][1] = my[ln][0];
      my[ln][0] = yi;
    end
    @(posedge clk); @(negedge clk);
    smp_valid = 0;
    check(req);
  endtask

  task automatic wr(int ln, int addr, int data);
    smp_valid = 0; cfg_we = 1; cfg_line = ln[0]; cfg_addr = 4'(addr); cfg_wdata = 16'(data);
    exp_v = 0;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
    if (addr < 8) mf[ln][addr] = longint'(signed'(16'(data)));
    else if (addr < 13) mb[ln][addr-8] = longint'(signed'(16'(data)));
    else if (addr == 13) mbyp[ln] = (16'(data) != 0);
    check("R9");
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7: got no completion, expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int l = 0; l < 2; l++) begin
      mbyp[l] = 1;
      for (int k = 0; k < 8; k++) begin mf[l][k] = 0; mx[l][k] = 0; end
      for (int k = 0; k < 5; k++) mb[l][k] = 0;
      my[l][0] = 0; my[l][1] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8");
    put(1, 0, 1234, -555, "R8");
    put(1, 1, -7, 30000, "R8");
    wr(0, 13, 0);
    put(1, 0, 20000, 1111, "R8");

    // R1 impulse through FIR taps on line 0
    for (int k = 0; k < 8; k++) wr(0, k, (k + 1) * 1500 * ((k % 2) ? -1 : 1));
    put(1, 0, 16384, 0, "R1");
    for (int k = 0; k < 9; k++) put(1, 0, 0, 100, "R1");

    // R2 biquad impulse, decaying feedback
    wr(0, 8, 16384); wr(0, 9, 8192); wr(0, 10, -4096);
    wr(0, 11, -8192); wr(0, 12, 4096);
    for (int k = 0; k < 8; k++) wr(0, k, 0);
    put(1, 0, 20000, 0, "R2");
    for (int k = 0; k < 12; k++) put(1, 0, 0, 0, "R2");
    // R2 feedback saturation: a1 near -2
    wr(0, 11, -32000); wr(0, 12, 16000);
    for (int k = 0; k < 10; k++) put(1, 0, 32767, 0, "R2");

    // R4 line 1 independent bank
    wr(1, 13, 0);
    wr(1, 0, 32767); wr(1, 3, -16384);
    for (int k = 0; k < 10; k++) put(1, 1, rnd16(), rnd16(), "R4");
    wr(1, 1, 9999);
    for (int k = 0; k < 4; k++) put(1, 0, rnd16(), rnd16(), "R4");

    // R3 interleaving with idle gaps
    for (int k = 0; k < 30; k++) begin
      put(1, k % 2, rnd16(), rnd16(), "R3");
      if (k % 3 == 0) put(0, 0, rnd16(), rnd16(), "R3");
    end
    for (int k = 0; k < 5; k++) put(0, 1, rnd16(), rnd16(), "R7");

    // R6 saturation on the output difference
    wr(1, 3, 0); wr(1, 1, 0);
    put(1, 1, -32768, 32767, "R6");
    put(1, 1, 0, 0, "R6");
    put(1, 1, 32767, -32768, "R6");

    // R5 bypass on line 0 while history advances
    wr(0, 13, 16'h0100);
    for (int k = 0; k < 10; k++) put(1, 0, rnd16(), rnd16(), "R5");
    wr(0, 13, 0);
    for (int k = 0; k < 5; k++) put(1, 0, rnd16(), rnd16(), "R5");

    // random coefficients and data on both lines
    wr(0, 11, -8192); wr(0, 12, 2048);
    for (int k = 0; k < 8; k++) begin wr(0, k, rnd16() / 4); wr(1, k, rnd16() / 4); end
    for (int k = 0; k < 400; k++) put($urandom_range(0, 3) != 0, $urandom_range(0, 1),
                                      rnd16(), rnd16(), "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule